// File: doc/BRIEF.md
# Pulse-Swallow Feedback Clock Divider

This block divides a fast clock by a programmable integer for the feedback path of a phase-locked loop. It does not run one wide counter at full speed. It uses three parts:

- a prescaler whose modulus is either 8 or 9;
- a swallow count that picks how many prescaler periods use the longer modulus;
- a main count of prescaler periods that closes each divide cycle.

The divide word is 11 bits. Bits [2:0] give the swallow value A and bits [10:3] give the main value M. The total ratio is M*8+A. The output is one pulse per divide cycle, and it is meant to drive a phase comparator.

The divide word is taken in only on the first clock of each divide cycle, so every cycle runs with one consistent setting. If the word in effect is not usable (M is zero, or A is not smaller than M), the block raises a flag, keeps its counters cleared and keeps the output low. While this state lasts it keeps watching the word, and it starts a fresh cycle as soon as the word becomes valid.

Top module: `pswallow_fbdiv`

## Requirements
- R1: While rst_n is low, fb_pulse is 0 and the counters are cleared; cfg_bad is 0 whenever a valid word is applied.
- R2: After reset is released with a valid word, the first fb_pulse is seen after exactly M*8+A rising edges of clk_in.
- R3: fb_pulse is high for exactly one clk_in cycle at a time.
- R4: The period between consecutive fb_pulse pulses is M*8+A clocks. A is div_word[2:0] and M is div_word[10:3]; for example M=3 with A=2 gives 26 and M=8 with A=7 gives 71.
- R5: With A=0 the period is M*8 (M=5 gives 40).
- R6: With A=1 the period is M*8+1 (M=4 gives 33).
- R7: div_word is captured on the first clock of each divide cycle. Changes later in the cycle do not change that cycle's length and do not raise cfg_bad; they take effect from the next cycle.
- R8: If the word in effect has M=0 or A>=M, cfg_bad is 1 and fb_pulse stays 0 for as long as that word is applied.
- R9: If a valid word is applied while cfg_bad is high, the next fb_pulse comes after exactly M*8+A clocks counted from the first edge that sees the valid word.
- R10: The extreme settings divide correctly: M=1 with A=0 gives 8, and M=255 with A=7 gives 2047.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_word | input | 11 | Divide setting: [10:3] main count M, [2:0] swallow count A |
| fb_pulse | output | 1 | One-clock pulse at the end of each divide cycle |
| cfg_bad | output | 1 | High while the word in effect is not a usable ratio |

## Verification
The pulse for a cycle is registered, so it becomes visible just after the M*8+A-th rising edge of that cycle. It falls after the next edge. The bench drives and samples on falling edges and counts samples from the release of reset, or from the previous pulse. It compares that count with M*8+A exactly, so a cycle that is one clock short or one clock long fails.

A new word applied on the sample where a pulse appears takes effect on the next edge, which is the first edge of the new cycle. A word changed in the middle of a cycle is expected only in the cycle after. cfg_bad depends combinationally on the word in effect, so it is checked on the first sample after an invalid word is applied at a cycle boundary.

// File: rtl/pswallow_fbdiv.sv
module pswallow_fbdiv #(
  parameter int A_W = 3,
  parameter int M_W = 8
) (
  input  logic                 clk_in,
  input  logic                 rst_n,
  input  logic [A_W+M_W-1:0]   div_word,
  output logic                 fb_pulse,
  output logic                 cfg_bad
);

  localparam int W   = A_W + M_W;
  localparam int P_W = A_W + 1;
  localparam logic [P_W-1:0] LAST_BASE = P_W'((2 ** A_W) - 1);
  localparam logic [P_W-1:0] LAST_ALT  = P_W'(2 ** A_W);

  logic [W-1:0]   cfg_q;
  logic           start_q;
  logic [P_W-1:0] pre_q;
  logic [M_W-1:0] m_q;

  logic [W-1:0]   cur;
  logic [A_W-1:0] cur_a;
  logic [M_W-1:0] cur_m;
  logic [M_W-1:0] cur_a_ext;
  logic           swallow;
  logic           per_end;
  logic           cyc_end;

  assign cur       = start_q ? div_word : cfg_q;
  assign cur_a     = cur[A_W-1:0];
  assign cur_m     = cur[W-1:A_W];
  assign cur_a_ext = M_W'(cur_a);
  assign cfg_bad   = (cur_m == '0) || (cur_a_ext >= cur_m);

  assign swallow = m_q < cur_a_ext;
  assign per_end = pre_q == (swallow ? LAST_ALT : LAST_BASE);
  assign cyc_end = per_end && (m_q == cur_m - M_W'(1));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      start_q  <= 1'b1;
      pre_q    <= '0;
      m_q      <= '0;
      fb_pulse <= 1'b0;
    end else if (cfg_bad) begin
      start_q  <= 1'b1;
      pre_q    <= '0;
      m_q      <= '0;
      fb_pulse <= 1'b0;
    end else begin
      if (start_q) cfg_q <= div_word;
      start_q  <= cyc_end;
      fb_pulse <= cyc_end;
      if (per_end) begin
        pre_q <= '0;
        m_q   <= cyc_end ? '0 : m_q + M_W'(1);
      end else begin
        pre_q <= pre_q + P_W'(1);
      end
    end
  end

  // R3: a pulse never lasts two clocks
  a_r3_single_pulse: assert property (@(posedge clk_in) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  // R8: an unusable word keeps the output quiet
  a_r8_bad_quiet: assert property (@(posedge clk_in) disable iff (!rst_n)
    cfg_bad |=> !fb_pulse);

  // R7: the captured setting holds for the whole cycle
  a_r7_cfg_hold: assert property (@(posedge clk_in) disable iff (!rst_n)
    !start_q |=> $stable(cfg_q));

  // R4: a cycle restarts the counters when it pulses
  a_r4_restart: assert property (@(posedge clk_in) disable iff (!rst_n)
    fb_pulse |-> (pre_q == '0 && m_q == '0));

  // R4: the prescaler count never runs past the longer modulus
  a_r4_pre_bound: assert property (@(posedge clk_in) disable iff (!rst_n)
    pre_q <= LAST_ALT);

endmodule

// File: tb/pswallow_fbdiv_tb.sv
`timescale 1ns/1ps
module pswallow_fbdiv_tb;
  logic        clk_in = 1'b0;
  logic        rst_n  = 1'b0;
  logic [10:0] div_word = '0;
  logic        fb_pulse;
  logic        cfg_bad;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #4 clk_in = ~clk_in;

  pswallow_fbdiv u_dut (
    .clk_in(clk_in), .rst_n(rst_n), .div_word(div_word),
    .fb_pulse(fb_pulse), .cfg_bad(cfg_bad)
  );

  function automatic logic [10:0] mk(input int m, input int a);
    return {m[7:0], a[2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_in) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // counts falling-edge samples until fb_pulse is seen; also reports the first sample
  task automatic measure(output int n, output bit first_hi);
    n = 0;
    first_hi = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_in);
      n++;
      if (i == 0) first_hi = fb_pulse;
      if (fb_pulse) return;
    end
    n = -1;
  endtask

  task automatic t_reset_and_first();
    int n;
    bit f;
    div_word = mk(3, 2);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_in);
    check(fb_pulse == 1'b0, "R1 pulse in reset", fb_pulse, 0);
    check(cfg_bad == 1'b0, "R1 flag in reset", cfg_bad, 0);
    rst_n = 1'b1;
    measure(n, f);
    check(n == 26, "R2 first pulse latency", n, 26);
  endtask

  task automatic t_ratio(input int m, input int a, input string req);
    int n;
    bit f;
    int exp;
    exp = m * 8 + a;
    div_word = mk(m, a);
    measure(n, f);
    check(n == exp, req, n, exp);
    check(f == 1'b0, "R3 pulse width", f, 0);
    measure(n, f);
    check(n == exp, req, n, exp);
  endtask

  task automatic t_midcycle();
    int n;
    int total;
    bit f;
    div_word = mk(4, 3);
    total = 0;
    repeat (5) begin
      @(negedge clk_in);
      total++;
    end
    div_word = mk(0, 0);
    @(negedge clk_in);
    total++;
    check(cfg_bad == 1'b0, "R7 no flag mid-cycle", cfg_bad, 0);
    repeat (3) begin
      @(negedge clk_in);
      total++;
    end
    div_word = mk(2, 1);
    measure(n, f);
    total += n;
    check(total == 35, "R7 cycle keeps captured word", total, 35);
    measure(n, f);
    check(n == 17, "R7 new word next cycle", n, 17);
  endtask

  task automatic t_invalid();
    int n;
    bit f;
    int seen;
    div_word = mk(2, 3);
    @(negedge clk_in);
    check(cfg_bad == 1'b1, "R8 flag A>=M", cfg_bad, 1);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_in);
      if (fb_pulse) seen++;
    end
    check(seen == 0, "R8 no pulse A>=M", seen, 0);
    div_word = mk(0, 0);
    @(negedge clk_in);
    check(cfg_bad == 1'b1, "R8 flag M=0", cfg_bad, 1);
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk_in);
      if (fb_pulse) seen++;
    end
    check(seen == 0, "R8 no pulse M=0", seen, 0);
    div_word = mk(3, 0);
    measure(n, f);
    check(n == 24, "R9 recovery latency", n, 24);
    check(cfg_bad == 1'b0, "R9 flag cleared", cfg_bad, 0);
  endtask

  initial begin
    t_reset_and_first();
    t_ratio(3, 2, "R4 ratio M3 A2");
    t_ratio(8, 7, "R4 ratio M8 A7");
    t_ratio(5, 0, "R5 ratio A0");
    t_ratio(4, 1, "R6 ratio A1");
    t_ratio(1, 0, "R10 ratio M1");
    t_ratio(255, 7, "R10 ratio M255 A7");
    t_midcycle();
    t_invalid();
    finish_run();
  end
endmodule